// File: doc/BRIEF.md
# AES3 Subframe Word Collector

This block sits behind a biphase-mark line decoder that has already recovered the bit clock and found the subframe preambles. The decoder presents five signals: a serial data bit, a bit-strobe level that rises once per data bit, a frame-sync level, a block-sync level and a line-activity flag. The collector turns that stream into parallel 28-bit words, one for each subframe, and routes each word to a channel A register or a channel B register.

Each subframe opens with a preamble. The decoder reports the preamble through the pair of sync levels: X gives frame-sync high and block-sync low, Y gives both low, and Z gives both high. The collector treats any change of that pair, or the first active cycle after the line was idle, as the start of a subframe. On a start it latches the channel, empties its bit counter and then takes one data bit on each of the next 28 rising edges of the strobe. The completed word goes to the latched channel's register together with a one-cycle write pulse. A Z start also raises a one-cycle block-start pulse. While the activity flag is low, every decoder input is treated as zero and any partial word is dropped.

Top module: `aes_subframe_deser`

## Requirements
- R1: A word holds 28 bits taken least significant first: the first data bit after a start goes to bit 0 and the 28th data bit goes to bit 27.
- R2: A channel's write output is high for exactly one clock, in the cycle after the clock edge that samples the 28th strobe rise. The channel's word output shows the new word in that same cycle and changes at no other time except at reset.
- R3: If frame-sync was high at the start, the word goes to channel A. If it was low, the word goes to channel B. The other channel's word and write output do not change.
- R4: A start is a change of the gated (frame-sync, block-sync) pair, or an active cycle that directly follows reset or an inactive cycle. Strobe rises that arrive after the 28th bit and before the next start are ignored.
- R5: When a start has block-sync high, block-start is high for exactly one clock, in the cycle after that start is sampled.
- R6: While the activity flag is low, no write and no block-start occur. Any partial word is discarded, and strobe rises during that time are not counted.
- R7: A start that arrives before 28 bits have been taken discards the partial word without a write, and a new word begins from bit 0.
- R8: A synchronous reset clears both word outputs, both write outputs and block-start to zero.
- R9: A bit is taken only on a strobe rise. A strobe that stays high for several clocks yields one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serData | input | 1 | Decoded serial data bit |
| bitStrobe | input | 1 | Bit strobe level; a rise marks a valid data bit |
| frameSync | input | 1 | High for a channel A preamble (X or Z) |
| blockSync | input | 1 | High for a Z preamble |
| lineActive | input | 1 | Decoder has lock; all other decoder inputs are ignored when low |
| chAWord | output | 28 | Last completed channel A word |
| chBWord | output | 28 | Last completed channel B word |
| chAWrite | output | 1 | One-cycle pulse when chAWord is updated |
| chBWrite | output | 1 | One-cycle pulse when chBWord is updated |
| blockStart | output | 1 | One-cycle pulse after a Z start |

## Verification
Every result of this block is registered once. A write pulse and its word appear in the cycle after the edge that samples the 28th strobe rise, and block-start appears in the cycle after the edge that samples a Z start. The bench drives inputs on the falling clock edge. Its behavioural model, built on a bit queue, updates on the rising edge, and all five outputs are compared with the model on the next falling edge. This places each comparison exactly one registered cycle after the stimulus that caused it. Directed checks then count write and block pulses across whole scenarios: discarded partial words, gated inactive periods, long strobes and extra strobes.

// File: rtl/aes_deser_pkg.sv
package aes_deser_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic shiftEn;    // take dataBit into the word being built
    logic dataBit;    // gated serial bit
    logic writeA;     // word complete, channel A
    logic writeB;     // word complete, channel B
    logic blockMark;  // start event with block-sync high
  } deserCtrl_t;

endpackage

// File: rtl/aes_deser_ctrl.sv
module aes_deser_ctrl
  import aes_deser_pkg::*;
#(
  parameter int WORD_BITS = 28
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       serData,
  input  logic       bitStrobe,
  input  logic       frameSync,
  input  logic       blockSync,
  input  logic       lineActive,
  output deserCtrl_t ctrl
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);

  // gated decoder inputs
  logic dataG, stbG, fsG, bsG;
  assign dataG = serData   & lineActive;
  assign stbG  = bitStrobe & lineActive;
  assign fsG   = frameSync & lineActive;
  assign bsG   = blockSync & lineActive;

  logic             stbPrev;
  logic             prevValid;
  logic             prevFs, prevBs;
  logic             armed;
  logic             latchA;
  logic [CNT_W-1:0] bitCnt;

  logic startEvt, stbEdge, takeBit, lastBit;

  always_comb begin
    startEvt = lineActive && (!prevValid || (fsG != prevFs) || (bsG != prevBs));
    stbEdge  = stbG && !stbPrev;
    takeBit  = lineActive && !startEvt && armed && stbEdge;
    lastBit  = takeBit && (bitCnt == LAST_IDX);

    ctrl.shiftEn   = takeBit;
    ctrl.dataBit   = dataG;
    ctrl.writeA    = lastBit && latchA;
    ctrl.writeB    = lastBit && !latchA;
    ctrl.blockMark = startEvt && bsG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stbPrev   <= 1'b0;
      prevValid <= 1'b0;
      prevFs    <= 1'b0;
      prevBs    <= 1'b0;
      armed     <= 1'b0;
      latchA    <= 1'b0;
      bitCnt    <= '0;
    end else begin
      stbPrev <= stbG;
      if (!lineActive) begin
        prevValid <= 1'b0;
        prevFs    <= 1'b0;
        prevBs    <= 1'b0;
        armed     <= 1'b0;
        bitCnt    <= '0;
      end else if (startEvt) begin
        prevValid <= 1'b1;
        prevFs    <= fsG;
        prevBs    <= bsG;
        armed     <= 1'b1;
        latchA    <= fsG;
        bitCnt    <= '0;
      end else if (takeBit) begin
        if (lastBit) begin
          armed  <= 1'b0;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aes_deser_dpath.sv
module aes_deser_dpath
  import aes_deser_pkg::*;
#(
  parameter int WORD_BITS = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  deserCtrl_t           ctrl,
  output logic [WORD_BITS-1:0] chAWord,
  output logic [WORD_BITS-1:0] chBWord,
  output logic                 chAWrite,
  output logic                 chBWrite,
  output logic                 blockStart
);
  localparam int NUM_CH = 2;

  logic [WORD_BITS-1:0] shiftQ;
  logic [WORD_BITS-1:0] nextWord;
  logic [NUM_CH-1:0]    chSel;
  logic [WORD_BITS-1:0] chWordQ [NUM_CH];
  logic [NUM_CH-1:0]    chWrQ;

  // right shift: first bit ends in bit 0
  assign nextWord = {ctrl.dataBit, shiftQ[WORD_BITS-1:1]};
  assign chSel    = {ctrl.writeB, ctrl.writeA};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ     <= '0;
      blockStart <= 1'b0;
    end else begin
      if (ctrl.shiftEn) shiftQ <= nextWord;
      blockStart <= ctrl.blockMark;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    always_ff @(posedge clk) begin
      if (rst) begin
        chWordQ[ch] <= '0;
        chWrQ[ch]   <= 1'b0;
      end else begin
        chWrQ[ch] <= chSel[ch];
        if (chSel[ch]) chWordQ[ch] <= nextWord;
      end
    end
  end

  assign chAWord  = chWordQ[0];
  assign chBWord  = chWordQ[1];
  assign chAWrite = chWrQ[0];
  assign chBWrite = chWrQ[1];

endmodule

// File: rtl/aes_subframe_deser.sv
module aes_subframe_deser
  import aes_deser_pkg::*;
#(
  parameter int WORD_BITS = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serData,
  input  logic                 bitStrobe,
  input  logic                 frameSync,
  input  logic                 blockSync,
  input  logic                 lineActive,
  output logic [WORD_BITS-1:0] chAWord,
  output logic [WORD_BITS-1:0] chBWord,
  output logic                 chAWrite,
  output logic                 chBWrite,
  output logic                 blockStart
);
  deserCtrl_t ctrl;

  aes_deser_ctrl #(.WORD_BITS(WORD_BITS)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .serData    (serData),
    .bitStrobe  (bitStrobe),
    .frameSync  (frameSync),
    .blockSync  (blockSync),
    .lineActive (lineActive),
    .ctrl       (ctrl)
  );

  aes_deser_dpath #(.WORD_BITS(WORD_BITS)) uDpath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .chAWord    (chAWord),
    .chBWord    (chBWord),
    .chAWrite   (chAWrite),
    .chBWrite   (chBWrite),
    .blockStart (blockStart)
  );

endmodule

// File: rtl/aes_deser_chk.sv
module aes_deser_chk #(
  parameter int WORD_BITS = 28
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 lineActive,
  input logic [WORD_BITS-1:0] chAWord,
  input logic [WORD_BITS-1:0] chBWord,
  input logic                 chAWrite,
  input logic                 chBWrite,
  input logic                 blockStart
);
  // R3
  one_channel_chk: assert property (@(posedge clk) disable iff (rst)
    !(chAWrite && chBWrite));

  // R2
  a_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chAWrite |=> !chAWrite);

  // R2
  b_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chBWrite |=> !chBWrite);

  // R2
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !chAWrite |-> $stable(chAWord));

  // R2
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !chBWrite |-> $stable(chBWord));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lineActive |=> (!chAWrite && !chBWrite && !blockStart));

  // R5
  block_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    blockStart |=> !blockStart);

endmodule

bind aes_subframe_deser aes_deser_chk #(.WORD_BITS(WORD_BITS)) uChk (
  .clk        (clk),
  .rst        (rst),
  .lineActive (lineActive),
  .chAWord    (chAWord),
  .chBWord    (chBWord),
  .chAWrite   (chAWrite),
  .chBWrite   (chBWrite),
  .blockStart (blockStart)
);

// File: tb/tb_aes_subframe_deser.sv
module tb_aes_subframe_deser;
  localparam int W = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serData = 1'b0, bitStrobe = 1'b0, frameSync = 1'b0, blockSync = 1'b0;
  logic lineActive = 1'b0;
  logic [W-1:0] chAWord, chBWord;
  logic chAWrite, chBWrite, blockStart;

  int checks = 0;
  int failures = 0;
  int nWrA = 0, nWrB = 0, nBlk = 0;

  always #4 clk = ~clk;  // 125 MHz

  aes_subframe_deser #(.WORD_BITS(W)) dut (.*);

  // behavioural reference model
  bit        mArmed = 0, mToA = 0, mStbPrev = 0;
  int        mPrevPair = -1;
  bit        mQ[$];
  logic [W-1:0] eA = '0, eB = '0;
  bit        eWrA = 0, eWrB = 0, eBlk = 0;

  always @(posedge clk) begin
    eWrA = 0; eWrB = 0; eBlk = 0;
    if (rst) begin
      eA = '0; eB = '0; mArmed = 0; mPrevPair = -1; mStbPrev = 0; mQ.delete();
    end else if (!lineActive) begin
      mArmed = 0; mPrevPair = -1; mStbPrev = 0; mQ.delete();
    end else begin
      int pair;
      pair = frameSync * 2 + blockSync;
      if (pair != mPrevPair) begin
        mPrevPair = pair; mArmed = 1; mToA = frameSync; eBlk = blockSync; mQ.delete();
      end else if (mArmed && bitStrobe && !mStbPrev) begin
        mQ.push_back(serData);
        if (mQ.size() == W) begin
          logic [W-1:0] w;
          for (int i = 0; i < W; i++) w[i] = mQ[i];
          if (mToA) begin eA = w; eWrA = 1; end
          else      begin eB = w; eWrB = 1; end
          mArmed = 0; mQ.delete();
        end
      end
      mStbPrev = bitStrobe;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, one registered cycle after the causing edge
  always @(negedge clk) begin
    if (!rst) begin
      check(chAWrite == eWrA, "R2 R3 chAWrite", chAWrite, eWrA);
      check(chBWrite == eWrB, "R2 R3 chBWrite", chBWrite, eWrB);
      check(chAWord == eA, "R1 R3 chAWord", chAWord, eA);
      check(chBWord == eB, "R1 R3 chBWord", chBWord, eB);
      check(blockStart == eBlk, "R5 blockStart", blockStart, eBlk);
      if (chAWrite) nWrA++;
      if (chBWrite) nWrB++;
      if (blockStart) nBlk++;
    end
  end

  task automatic preamble(input bit fs, input bit bs);
    @(negedge clk);
    frameSync = fs; blockSync = bs; bitStrobe = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBits(input logic [W-1:0] w, input int n, input int hi);
    for (int i = 0; i < n; i++) begin
      serData = w[i]; bitStrobe = 1;
      repeat (hi) @(negedge clk);
      bitStrobe = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [W-1:0] w1 = 28'hA5C3_96E, w2 = 28'h0F0_F0F1, w3 = 28'h8000_001;
    logic [W-1:0] w4 = 28'h123_4567, w5 = 28'hFED_CBA9, w6 = 28'h555_AAA3;
    repeat (4) @(negedge clk);
    // R8: reset state
    check(chAWord == 0 && chBWord == 0, "R8 words", {chAWord, chBWord}, 0);
    check(!chAWrite && !chBWrite && !blockStart, "R8 pulses", {chAWrite, chBWrite, blockStart}, 0);
    rst = 0; lineActive = 1;
    repeat (3) @(negedge clk);

    // Z then Y then X: routing and block start
    preamble(1, 1); sendBits(w1, W, 2); repeat (2) @(negedge clk);
    check(chAWord == w1, "R1 Z word", chAWord, w1);
    check(nWrA == 1 && nBlk == 1, "R5 Z block pulse", nBlk, 1);
    preamble(0, 0); sendBits(w2, W, 1); repeat (2) @(negedge clk);
    check(chBWord == w2 && chAWord == w1, "R3 Y to B", chBWord, w2);
    preamble(1, 0); sendBits(w3, W, 5); repeat (2) @(negedge clk);
    check(chAWord == w3 && nWrA == 2, "R9 long strobe one bit", chAWord, w3);

    // R7: partial Y interrupted by X preamble
    preamble(0, 0); sendBits(w5, 10, 2);
    preamble(1, 0); sendBits(w4, W, 2); repeat (2) @(negedge clk);
    check(nWrB == 1, "R7 partial dropped", nWrB, 1);
    check(chAWord == w4, "R7 fresh word", chAWord, w4);

    // R6: line drops mid-word, strobes while idle are ignored
    preamble(0, 0); sendBits(w6, 12, 2);
    lineActive = 0; sendBits(w6, 3, 1); frameSync = 1; blockSync = 1;
    repeat (2) @(negedge clk);
    check(nWrB == 1 && nBlk == 1, "R6 nothing while idle", nWrB, 1);
    frameSync = 0; blockSync = 0; lineActive = 1;
    repeat (2) @(negedge clk);
    sendBits(w5, W, 2); repeat (2) @(negedge clk);
    check(chBWord == w5 && nWrB == 2, "R6 restart after idle", chBWord, w5);

    // R4: extra strobes after a full word
    sendBits(w1, 6, 2); repeat (2) @(negedge clk);
    check(nWrB == 2 && nWrA == 3, "R4 extra strobes ignored", nWrB, 2);

    // second block start
    preamble(1, 1); sendBits(w6, W, 3); repeat (2) @(negedge clk);
    check(chAWord == w6 && nBlk == 2, "R5 second block", nBlk, 2);
    check(nWrA == 4, "R3 A count", nWrA, 4);

    finishRun();
  end
endmodule